// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Controller

This block turns a 32.768 kHz tick into a programmable square wave and a periodic event, and gathers that event together with externally generated alarm and update-ended pulses into three sticky flags. Each flag has its own enable. The enabled flags combine into an interrupt summary bit and an active-low open-drain style interrupt request. A 15-stage ripple-style divider advances on every tick while the oscillator-select pattern is the run pattern. A 4-bit rate code picks one stage of that divider. The chosen stage is the square-wave output, gated by its own enable, and its rising edge sets the periodic flag.

Software reads the flags through a status read strobe. The first cycle of a read captures a snapshot and clears every flag. Events that arrive while the strobe is held are parked and land in the flags when the read ends, so none is lost. The active-low reset clears the four enables and all flags and restarts the divider. The rate code, oscillator select and freeze bit are inputs held outside the block and are not affected by it.

Top module: `pirq_sqw_ctrl`

## Requirements
- R1: With `tick_i` high every cycle, the square-wave period in ticks is 32768/f for the rate code on `rate_i`. The frequency f is 8192, 4096, 2048, 1024 and 512 Hz for codes 3 to 7 and 64, 32, 16, 8, 4 and 2 Hz for codes 10 to 15. Codes 1 and 8 both give 256 Hz, and codes 2 and 9 both give 128 Hz.
- R2: Rate code 0 produces no square-wave activity and never sets the periodic flag.
- R3: The divider runs only while `osc_sel_i` is 3'b010. Any other pattern holds it cleared, so the square wave stays low and no periodic events occur.
- R4: When the square-wave enable is 1, `sqw_o` is the selected divider stage, high for exactly half of each period. When that enable is 0, `sqw_o` is low.
- R5: The periodic flag is set on each rising edge of the selected stage, whatever its enable. A one-cycle pulse on `alarm_evt_i` sets the alarm flag and a pulse on `upd_evt_i` sets the update flag, also whatever their enables.
- R6: IRQF = PF·PIE + AF·AIE + UF·UIE·!SET, and `irq_no` is 0 exactly while IRQF is 1. Enabling an interrupt whose flag is already set pulls `irq_no` low in the cycle after the enable write.
- R7: The update flag requests an interrupt only while `set_i` is 0.
- R8: A read strobe rising on `rd_c_i` captures {IRQF, PF, AF, UF} into `status_o` bits 7..4 (bits 3..0 read 0), and clears all flags on the same edge.
- R9: Events that arrive while `rd_c_i` stays high after its first cycle are held, and they set their flags on the edge where the strobe falls.
- R10: `rst_ni` low clears the enables and all flags and zeroes the divider. After it, `irq_no` is 1, `sqw_o` is 0 and a read returns 0. The enables are written by `en_we_i` with `en_wdata_i` = {PIE, AIE, UIE, SQWE} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz clock enable |
| osc_sel_i | input | 3 | Oscillator select pattern; 3'b010 runs the divider |
| rate_i | input | 4 | Rate code selecting the divider stage |
| set_i | input | 1 | Freeze bit; masks the update interrupt while 1 |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | {PIE, AIE, UIE, SQWE} |
| alarm_evt_i | input | 1 | Alarm match pulse |
| upd_evt_i | input | 1 | Update-ended pulse |
| rd_c_i | input | 1 | Status read strobe, held for the read |
| status_o | output | 8 | Read snapshot {IRQF, PF, AF, UF, 4'b0} |
| sqw_o | output | 1 | Square-wave output |
| irq_no | output | 1 | Interrupt request, low while IRQF is 1 |

## Verification
On every cycle, the in-RTL properties check the following: a read clears the flags on its first edge; an idle event sets its flag on the next edge; a parked event lands when the strobe falls; a stopped oscillator leaves the divider at zero; rate code 0 keeps the tap low; and a disabled square wave stays low. Two further checks hold each cycle: an enabled periodic flag holds the request low, and a set freeze bit never lets the update flag alone assert it. The exact period and duty for every rate code, including the aliased pairs, can only be shown by the bench's measurements. The same holds for the content of the snapshot and the full reset sequence, which the bench compares against its behavioural model on every clock.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int RATE_W = 4;
  localparam int NFLAG  = 3;
  localparam int F_UF   = 0;
  localparam int F_AF   = 1;
  localparam int F_PF   = 2;
  localparam int EN_SQWE = 0;
  localparam int EN_UIE  = 1;
  localparam int EN_AIE  = 2;
  localparam int EN_PIE  = 3;
  localparam logic [2:0] OSC_RUN = 3'b010;

  // divider stage feeding a rate code; codes 1/2 alias 8/9
  function automatic int unsigned tap_index(input logic [RATE_W-1:0] code);
    case (code)
      4'd1:    return 6;
      4'd2:    return 7;
      default: return int'(code) - 2;
    endcase
  endfunction
endpackage

// File: rtl/pirq_divider.sv
module pirq_divider import pirq_pkg::*; #(
  parameter int DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tap_o,
  output logic              rise_o
);
  localparam int IDX_W = $clog2(DIV_W);

  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx;
  logic [DIV_W-1:0] lo_mask, hi_mask;
  logic             active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + DIV_W'(1);
  end

  assign active  = (rate_i != '0);
  assign idx     = IDX_W'(tap_index(rate_i));
  assign lo_mask = (DIV_W'(1) << idx) - DIV_W'(1);
  assign hi_mask = (DIV_W'(2) << idx) - DIV_W'(1);
  assign tap_o   = active && |(cnt_q & (DIV_W'(1) << idx));
  // next tick carries into the selected stage
  assign rise_o  = tick_i && run_i && active && ((cnt_q & hi_mask) == lo_mask);

  assert_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  assert_code_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |-> (!tap_o && !rise_o));
  assert_rise_tap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (tap_o || (rate_i != $past(rate_i))));
endmodule

// File: rtl/pirq_flag_cell.sv
module pirq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_start_i,
  input  logic rd_hold_i,
  input  logic rd_end_i,
  output logic flag_o
);
  logic flag_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (rd_start_i) begin
      flag_q <= 1'b0;
      pend_q <= evt_i;
    end else if (rd_hold_i) begin
      pend_q <= pend_q | evt_i;
    end else if (rd_end_i) begin
      flag_q <= pend_q | evt_i;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_q | evt_i;
    end
  end

  assign flag_o = flag_q;

  assert_clear_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |=> !flag_o);
  assert_idle_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !rd_start_i && !rd_hold_i && !rd_end_i) |=> flag_o);
  assert_held_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_end_i && pend_q) |=> flag_o);
endmodule

// File: rtl/pirq_sqw_ctrl.sv
module pirq_sqw_ctrl import pirq_pkg::*; #(
  parameter int DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        osc_sel_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              set_i,
  input  logic              en_we_i,
  input  logic [3:0]        en_wdata_i,
  input  logic              alarm_evt_i,
  input  logic              upd_evt_i,
  input  logic              rd_c_i,
  output logic [7:0]        status_o,
  output logic              sqw_o,
  output logic              irq_no
);
  logic [3:0]       en_q;
  logic             rd_q;
  logic [3:0]       snap_q;
  logic             tap, rise, irqf;
  logic             rd_start, rd_hold, rd_end;
  logic [NFLAG-1:0] evt, flag;

  pirq_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (osc_sel_i == OSC_RUN),
    .rate_i (rate_i),
    .tap_o  (tap),
    .rise_o (rise)
  );

  assign rd_start = rd_c_i && !rd_q;
  assign rd_hold  = rd_c_i && rd_q;
  assign rd_end   = !rd_c_i && rd_q;

  always_comb begin
    evt       = '0;
    evt[F_PF] = rise;
    evt[F_AF] = alarm_evt_i;
    evt[F_UF] = upd_evt_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    pirq_flag_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[g]),
      .rd_start_i (rd_start),
      .rd_hold_i  (rd_hold),
      .rd_end_i   (rd_end),
      .flag_o     (flag[g])
    );
  end

  assign irqf = (flag[F_PF] && en_q[EN_PIE]) ||
                (flag[F_AF] && en_q[EN_AIE]) ||
                (flag[F_UF] && en_q[EN_UIE] && !set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rd_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      rd_q <= rd_c_i;
      if (en_we_i)  en_q   <= en_wdata_i;
      if (rd_start) snap_q <= {irqf, flag[F_PF], flag[F_AF], flag[F_UF]};
    end
  end

  assign status_o = {snap_q, 4'b0000};
  assign sqw_o    = en_q[EN_SQWE] && tap;
  assign irq_no   = !irqf;

  assert_sqw_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[EN_SQWE] |-> !sqw_o);
  assert_pie_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[EN_PIE] && flag[F_PF]) |-> !irq_no);
  assert_set_masks_uf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !(flag[F_PF] && en_q[EN_PIE]) && !(flag[F_AF] && en_q[EN_AIE])) |-> irq_no);
endmodule

// File: tb/pirq_sqw_ctrl_bench.sv
module pirq_sqw_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tick = 1'b0;
  logic [2:0] osc = 3'b000;
  logic [3:0] rate = 4'd0;
  logic       set_b = 1'b0;
  logic       en_we = 1'b0;
  logic [3:0] en_wd = 4'd0;
  logic       alarm = 1'b0;
  logic       upd = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] status;
  logic       sqw, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pirq_sqw_ctrl u_pirq_sqw_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_sel_i(osc), .rate_i(rate),
    .set_i(set_b), .en_we_i(en_we), .en_wdata_i(en_wd), .alarm_evt_i(alarm),
    .upd_evt_i(upd), .rd_c_i(rd), .status_o(status), .sqw_o(sqw), .irq_no(irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hz(input int code);
    case (code)
      1, 8: return 256;
      2, 9: return 128;
      3: return 8192;  4: return 4096;  5: return 2048;
      6: return 1024;  7: return 512;   10: return 64;
      11: return 32;   12: return 16;   13: return 8;
      14: return 4;    15: return 2;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model
  int m_cnt;
  bit m_pie, m_aie, m_uie, m_sqwe, m_rdq;
  bit m_flag[3], m_pend[3];
  bit [3:0] m_snap;

  function automatic bit m_irqf();
    return (m_flag[2] && m_pie) || (m_flag[1] && m_aie) || (m_flag[0] && m_uie && !set_b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pie = 0; m_aie = 0; m_uie = 0; m_sqwe = 0; m_rdq = 0; m_snap = 0;
      for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_pend[i] = 0; end
    end else begin
      bit ev[3];
      bit irqf_pre;
      int h;
      irqf_pre = m_irqf();
      ev[2] = 0; ev[1] = alarm; ev[0] = upd;
      if (osc == 3'b010) begin
        if (tick) begin
          m_cnt = (m_cnt + 1) % 32768;
          h = hz(int'(rate));
          if (h != 0 && (m_cnt % (32768 / h)) == (16384 / h)) ev[2] = 1;
        end
      end else m_cnt = 0;
      if (rd && !m_rdq) m_snap = {irqf_pre, m_flag[2], m_flag[1], m_flag[0]};
      for (int i = 0; i < 3; i++) begin
        if (rd && !m_rdq) begin m_flag[i] = 0; m_pend[i] = ev[i]; end
        else if (rd && m_rdq) m_pend[i] = m_pend[i] | ev[i];
        else if (!rd && m_rdq) begin m_flag[i] = m_pend[i] | ev[i]; m_pend[i] = 0; end
        else m_flag[i] = m_flag[i] | ev[i];
      end
      m_rdq = rd;
      if (en_we) {m_pie, m_aie, m_uie, m_sqwe} = en_wd;
    end
    #5;
    if (!done) begin
      int h2;
      int e_sqw;
      h2 = hz(int'(rate));
      e_sqw = (m_sqwe && h2 != 0) ? ((m_cnt / (16384 / h2)) % 2) : 0;
      chk("R4 sqw model", int'(sqw), e_sqw);
      chk("R6 irq model", int'(irq_n), int'(!m_irqf()));
      chk("R8 status model", int'(status), int'({m_snap, 4'b0000}));
    end
  end

  task automatic wr_en(input logic [3:0] v);
    en_we = 1; en_wd = v;
    @(negedge clk);
    en_we = 0;
  endtask

  task automatic rdc(output logic [7:0] s);
    rd = 1;
    @(negedge clk);
    s = status;
    rd = 0;
    @(negedge clk);
  endtask

  task automatic pulse_alarm();
    alarm = 1; @(negedge clk); alarm = 0;
  endtask

  task automatic pulse_upd();
    upd = 1; @(negedge clk); upd = 0;
  endtask

  task automatic measure(input int code);
    int hi, per, half;
    half = 16384 / hz(code);
    rate = 4'(code);
    @(negedge clk);
    while (sqw !== 1'b0) @(negedge clk);
    while (sqw !== 1'b1) @(negedge clk);
    hi = 0;
    while (sqw === 1'b1) begin @(negedge clk); hi++; end
    per = hi;
    while (sqw === 1'b0) begin @(negedge clk); per++; end
    chk($sformatf("R1 period code %0d", code), per, 2 * half);
    chk($sformatf("R4 high time code %0d", code), hi, half);
  endtask

  initial begin
    logic [7:0] s;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset sqw", int'(sqw), 0);
    chk("R10 reset irq", int'(irq_n), 1);
    chk("R10 reset status", int'(status), 0);

    // oscillator stopped
    wr_en(4'b0001);
    tick = 1; rate = 4'd3; osc = 3'b000;
    repeat (64) @(negedge clk);
    chk("R3 stopped sqw", int'(sqw), 0);
    osc = 3'b110;
    repeat (64) @(negedge clk);
    chk("R3 held sqw", int'(sqw), 0);
    rdc(s);
    chk("R3 no periodic flag", int'(s[6]), 0);

    // rate code zero
    osc = 3'b010; rate = 4'd0;
    repeat (200) @(negedge clk);
    chk("R2 code zero sqw", int'(sqw), 0);
    rdc(s);
    chk("R2 code zero flag", int'(s[6]), 0);

    for (int c = 1; c < 16; c++) measure(c);

    // periodic flag without enable
    rate = 4'd3;
    repeat (10) @(negedge clk);
    chk("R5 pf no irq", int'(irq_n), 1);
    rdc(s);
    chk("R5 pf set with pie 0", int'(s[6]), 1);
    chk("R6 irqf clear", int'(s[7]), 0);
    repeat (6) @(negedge clk);
    wr_en(4'b1000);
    chk("R6 pie on pending pf", int'(irq_n), 0);
    osc = 3'b000;
    rdc(s);
    chk("R8 irqf in snapshot", int'(s[7]), 1);
    chk("R8 irq released by read", int'(irq_n), 1);

    wr_en(4'b0000);
    pulse_alarm();
    pulse_upd();
    chk("R5 af uf no irq", int'(irq_n), 1);
    rdc(s);
    chk("R5 af uf flags", int'(s[5:4]), 3);

    pulse_alarm();
    wr_en(4'b0100);
    chk("R6 aie on pending af", int'(irq_n), 0);
    rdc(s);
    chk("R8 af snapshot", int'(s), 8'hA0);

    // update interrupt gated by set
    wr_en(4'b0010);
    set_b = 1;
    pulse_upd();
    chk("R7 uf masked by set", int'(irq_n), 1);
    set_b = 0;
    @(negedge clk);
    chk("R7 uf with set 0", int'(irq_n), 0);
    rdc(s);
    chk("R8 uf snapshot", int'(s), 8'h90);

    // event during read is held
    wr_en(4'b0100);
    rd = 1;
    @(negedge clk);
    alarm = 1;
    @(negedge clk);
    alarm = 0;
    s = status;
    chk("R9 snapshot excludes late event", int'(s[5]), 0);
    chk("R9 no irq during read", int'(irq_n), 1);
    @(negedge clk);
    rd = 0;
    @(negedge clk);
    chk("R9 held event lands", int'(irq_n), 0);

    // reset mid-operation
    wr_en(4'b1111);
    osc = 3'b010; rate = 4'd3;
    pulse_upd();
    repeat (8) @(negedge clk);
    osc = 3'b000;
    rst_n = 0;
    @(negedge clk);
    chk("R10 irq in reset", int'(irq_n), 1);
    chk("R10 sqw in reset", int'(sqw), 0);
    rst_n = 1;
    osc = 3'b010;
    repeat (20) @(negedge clk);
    chk("R10 sqwe cleared", int'(sqw), 0);
    chk("R10 enables cleared", int'(irq_n), 1);
    osc = 3'b000;
    @(negedge clk);
    rdc(s);
    chk("R10 af uf cleared", int'(s[5:4]), 0);

    // slow tick pattern
    osc = 3'b010; rate = 4'd3; tick = 0;
    wr_en(4'b0001);
    for (int i = 0; i < 60; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    tick = 0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule